// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface

This block models a byte-wide non-volatile memory that is driven through a command decoder rather than plain RAM writes. An internal byte array (1 KiB by default, split into 256-byte erase blocks) powers up holding all-ones. It sits on a simple synchronous memory-mapped bus with an address, write data, a write strobe, a read strobe and registered read data.

Writes on the bus are command bytes. Some commands take one bus cycle and only select what reads return: array contents, the status register or a 16-bit device identifier. Others take two bus cycles. Byte program stores a byte. Erase setup followed by a confirm byte clears a whole block back to 0xFF. A wrong confirm byte raises error bits in the status register, and those bits stay set until software clears them. A block erase runs as an internal sweep of one byte per clock. While it runs a busy output is high and bus writes are ignored.

Top module: `flash_cmd_core`

## Requirements
- R1: After reset the read mode is array read, the status register is 0x00, the decoder expects a first-cycle command, busy is low and bus_rdata is 0xFF. At power-up every array byte holds 0xFF.
- R2: A read strobed in one cycle presents its data on bus_rdata after the next rising edge. The data holds until the next read. In array-read mode the data is the stored byte, or 0xFF when the address is at or above the array size.
- R3: First-cycle bytes 0xFF (array read), 0x70 (status read), 0x90 (ID read) and 0xB0 (suspend/resume) change only the read mode. In the 0xB0 mode, and in any mode left by a program or erase sequence, reads return 0xFF.
- R4: A first-cycle byte that is not a recognised first-cycle command (for example 0x33 or 0xD0) changes nothing.
- R5: A first-cycle 0x50 clears the status register to 0x00 and selects array-read mode.
- R6: A first-cycle 0x10 or 0x40, with any address, followed by a second write stores that write's data at that write's address. A second-cycle address outside the array stores nothing. The mode afterwards stays the program command, so reads return 0xFF until a mode command is written.
- R7: A first-cycle 0x20 followed by a second write of 0xD0 to an in-range address fills the whole block containing that address with 0xFF. The block base is the address with its low log2(block size) bits cleared. busy is high for exactly one cycle per block byte, starting after the confirming edge, and other blocks keep their data. A confirm to an out-of-range address erases nothing and does not raise busy.
- R8: A first-cycle 0x20 followed by any second byte other than 0xD0 sets status bits 0x20 (erase error) and 0x10 (byte-write error) and selects status-read mode. These bits stay set through mode changes until a 0x50.
- R9: Status bits 0x80 (ready), 0x40 (erase suspended) and 0x08 (low programming voltage) and reserved bits 2..0 always read 0, so the status register only ever reads 0x00 or 0x30.
- R10: In ID mode a read at an odd address returns DEV_ID[15:8] and a read at an even address returns DEV_ID[7:0].
- R11: Bus writes made while busy is high are ignored, both command and data bytes.
- R12: When a read and a write are strobed in the same cycle, the read returns what the mode in force before that write selects.
- R13: After any second-cycle write the decoder expects a first-cycle command again, so the next byte is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Byte address for reads and writes |
| bus_wdata | input | 8 | Command or data byte |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| busy | output | 1 | High while a block erase sweep runs |

## Verification
The hardest situation to reach is a bus write that arrives while an erase sweep is still running. If that write were accepted, it would start a program sequence whose data lands in a different block. The bench issues a program command and a data byte right after the confirm, inside the sixteen-cycle sweep of its small configuration. After the sweep it reads back the target byte in the untouched block. The other hard case is a read and a write strobed together. The bench drives both strobes in one cycle and checks that the returned byte follows the old mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CMD_PROG_A  = 8'h10;
  localparam byte_t CMD_ERASE   = 8'h20;
  localparam byte_t CMD_PROG_B  = 8'h40;
  localparam byte_t CMD_STS_CLR = 8'h50;
  localparam byte_t CMD_STS_RD  = 8'h70;
  localparam byte_t CMD_ID_RD   = 8'h90;
  localparam byte_t CMD_SUSPEND = 8'hB0;
  localparam byte_t CMD_CONFIRM = 8'hD0;
  localparam byte_t CMD_ARRAY   = 8'hFF;

  localparam byte_t STS_ERASE_ERR = 8'h20;
  localparam byte_t STS_WRITE_ERR = 8'h10;
  localparam byte_t ERASED_BYTE   = 8'hFF;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int BUS_AW    = 12,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [BUS_AW-1:0] addr,
  input  byte_t             wdata,
  output byte_t             mode_q,
  output byte_t             status_q,
  output logic              cyc_q,
  output logic              prog_en,
  output logic              erase_go
);
  localparam logic [BUS_AW:0] LIMIT = (BUS_AW+1)'(MEM_BYTES);

  logic in_range, is_prog;
  assign in_range = ({1'b0, addr} < LIMIT);
  assign is_prog  = (mode_q == CMD_PROG_A) || (mode_q == CMD_PROG_B);
  assign prog_en  = wr_ok && cyc_q && is_prog && in_range;
  assign erase_go = wr_ok && cyc_q && (mode_q == CMD_ERASE) &&
                    (wdata == CMD_CONFIRM) && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= CMD_ARRAY;
      status_q <= '0;
      cyc_q    <= 1'b0;
    end else if (wr_ok) begin
      if (!cyc_q) begin
        case (wdata)
          CMD_ARRAY, CMD_STS_RD, CMD_ID_RD, CMD_SUSPEND: mode_q <= wdata;
          CMD_STS_CLR: begin
            status_q <= '0;
            mode_q   <= CMD_ARRAY;
          end
          CMD_PROG_A, CMD_PROG_B, CMD_ERASE: begin
            mode_q <= wdata;
            cyc_q  <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        cyc_q <= 1'b0;
        if (mode_q == CMD_ERASE && wdata != CMD_CONFIRM) begin
          mode_q   <= CMD_STS_RD;
          status_q <= status_q | STS_ERASE_ERR | STS_WRITE_ERR;
        end
      end
    end
  end
endmodule

// File: rtl/flash_erase_sweep.sv
module flash_erase_sweep #(
  parameter int MEM_BYTES = 1024,
  parameter int BLK_BYTES = 256,
  localparam int MEM_AW   = $clog2(MEM_BYTES),
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int IDX_W    = MEM_AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_blk,
  output logic              busy,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BLK_BYTES - 1);

  logic [IDX_W-1:0] blk_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      blk_q <= '0;
      off_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      blk_q <= start_blk;
      off_q <= '0;
    end else if (busy) begin
      off_q <= off_q + 1'b1;
      if (off_q == LAST) busy <= 1'b0;
    end
  end

  assign wr_en   = busy;
  assign wr_addr = {blk_q, off_q};
endmodule

// File: rtl/flash_byte_store.sv
module flash_byte_store
  import flash_cmd_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  byte_t             wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output byte_t             rdata
);
  byte_t mem [MEM_BYTES];

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = ERASED_BYTE;
  end

  // read-first single clock block RAM
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/flash_cmd_core.sv
module flash_cmd_core
  import flash_cmd_pkg::*;
#(
  parameter int          BUS_AW    = 12,
  parameter int          MEM_BYTES = 1024,
  parameter int          BLK_BYTES = 256,
  parameter logic [15:0] DEV_ID    = 16'h4E2B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              busy
);
  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam logic [BUS_AW:0] LIMIT = (BUS_AW+1)'(MEM_BYTES);

  byte_t             mode_q, status_q, mem_rdata, alt_q, mem_wdata;
  logic              cyc_q, prog_en, erase_go, wr_ok, in_range, use_mem_q;
  logic              sweep_we, mem_we;
  logic [MEM_AW-1:0] sweep_addr, mem_waddr;

  assign wr_ok    = bus_we && !busy;
  assign in_range = ({1'b0, bus_addr} < LIMIT);

  flash_cmd_decode #(.BUS_AW(BUS_AW), .MEM_BYTES(MEM_BYTES)) u_dec (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .status_q(status_q), .cyc_q(cyc_q),
    .prog_en(prog_en), .erase_go(erase_go)
  );

  flash_erase_sweep #(.MEM_BYTES(MEM_BYTES), .BLK_BYTES(BLK_BYTES)) u_sweep (
    .clk(clk), .rst(rst), .start(erase_go),
    .start_blk(bus_addr[MEM_AW-1:OFF_W]),
    .busy(busy), .wr_en(sweep_we), .wr_addr(sweep_addr)
  );

  assign mem_we    = sweep_we || prog_en;
  assign mem_waddr = sweep_we ? sweep_addr : bus_addr[MEM_AW-1:0];
  assign mem_wdata = sweep_we ? ERASED_BYTE : bus_wdata;

  flash_byte_store #(.MEM_BYTES(MEM_BYTES)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(bus_re), .raddr(bus_addr[MEM_AW-1:0]), .rdata(mem_rdata)
  );

  // read steering uses the mode held before any same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      use_mem_q <= 1'b0;
      alt_q     <= ERASED_BYTE;
    end else if (bus_re) begin
      use_mem_q <= 1'b0;
      alt_q     <= ERASED_BYTE;
      case (mode_q)
        CMD_ARRAY:  use_mem_q <= in_range;
        CMD_STS_RD: alt_q <= status_q;
        CMD_ID_RD:  alt_q <= bus_addr[0] ? DEV_ID[15:8] : DEV_ID[7:0];
        default: ;
      endcase
    end
  end

  assign bus_rdata = use_mem_q ? mem_rdata : alt_q;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int BLK_BYTES = 256,
  localparam int CW       = $clog2(BLK_BYTES) + 1
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic       bus_re,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       busy,
  input logic [7:0] status,
  input logic       cyc
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  // R7
  erase_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(bus_we) && $past(bus_wdata) == 8'hD0));

  // R7
  erase_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < CW'(BLK_BYTES)));

  // R7
  erase_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(run_cnt) == CW'(BLK_BYTES - 1)));

  // R9
  status_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (status == 8'h00) || (status == 8'h30));

  // R8
  status_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> $past(bus_we));

  // R13
  cyc_return_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc && bus_we && !busy) |=> !cyc);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(status) && $stable(cyc)));
endmodule

bind flash_cmd_core flash_cmd_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
  .status(status_q), .cyc(cyc_q)
);

// File: tb/sim_flash_cmd_core.sv
module sim_flash_cmd_core;
  localparam int          AW = 7;
  localparam int          MB = 64;
  localparam int          BB = 16;
  localparam logic [15:0] ID = 16'hA57C;

  logic          clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0, rdata;
  logic          we = 1'b0, re = 1'b0, busy;

  always #5 clk = ~clk;

  flash_cmd_core #(.BUS_AW(AW), .MEM_BYTES(MB), .BLK_BYTES(BB), .DEV_ID(ID)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [MB];
  logic [7:0] got;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = a[AW-1:0]; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); addr = a[AW-1:0]; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic sweep_all(input string tag);
    for (int a = 0; a < 2 * MB; a++) begin
      rd(a, got);
      check(tag, got, (a < MB) ? ref_mem[a] : 8'hFF);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < MB; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rdata", rdata, 8'hFF);
    check("R1 reset busy", {7'd0, busy}, 8'h00);
    sweep_all("R1 R2 power-up array");

    // R6: program every byte, first-cycle address scrambled
    for (int a = 0; a < MB; a++) begin
      wr(~a, (a % 2) ? 8'h10 : 8'h40);
      wr(a, 8'((a * 7 + 3) & 8'hFF));
      ref_mem[a] = 8'((a * 7 + 3) & 8'hFF);
    end
    wr(0, 8'hFF);
    sweep_all("R2 R6 programmed array");

    // R6: out-of-range program dropped, mode stays program
    wr(0, 8'h40); wr(MB + 5, 8'h00);
    rd(5, got); check("R6 program mode reads FF", got, 8'hFF);
    wr(0, 8'hFF);
    rd(5, got); check("R6 out-of-range dropped", got, ref_mem[5]);

    // R3 / R10 / R4
    wr(0, 8'hB0); rd(3, got); check("R3 suspend mode FF", got, 8'hFF);
    wr(0, 8'h70); rd(3, got); check("R3 status mode", got, 8'h00);
    wr(0, 8'h90);
    for (int a = 0; a < 2 * MB; a++) begin
      rd(a, got); check("R10 id byte", got, (a % 2) ? ID[15:8] : ID[7:0]);
    end
    wr(9, 8'h33); rd(2, got); check("R4 unknown ignored", got, ID[7:0]);
    wr(9, 8'hD0); rd(3, got); check("R4 stray confirm ignored", got, ID[15:8]);
    wr(0, 8'hFF); rd(4, got); check("R3 back to array", got, ref_mem[4]);

    // R7: erase block 1 through a mid-block address, count busy
    wr(0, 8'h20); wr(BB + 9, 8'hD0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R7 busy length", 8'(cnt), 8'(BB));
    for (int i = BB; i < 2 * BB; i++) ref_mem[i] = 8'hFF;
    wr(0, 8'hFF);
    sweep_all("R7 block erased");

    // R11: writes during sweep ignored
    wr(0, 8'h20); wr(2 * BB + 8, 8'hD0);
    check("R11 busy raised", {7'd0, busy}, 8'h01);
    wr(0, 8'h40); wr(3, 8'h00);
    wait_idle();
    for (int i = 2 * BB; i < 3 * BB; i++) ref_mem[i] = 8'hFF;
    wr(0, 8'hFF);
    rd(3, got); check("R11 write during busy ignored", got, ref_mem[3]);
    rd(2 * BB, got); check("R7 block 2 erased", got, 8'hFF);
    rd(3 * BB, got); check("R7 block 3 kept", got, ref_mem[3 * BB]);

    // R7: out-of-range confirm
    wr(0, 8'h20); wr(MB + 20, 8'hD0);
    check("R7 no busy out of range", {7'd0, busy}, 8'h00);
    wr(0, 8'hFF);
    sweep_all("R7 nothing erased out of range");

    // R8 / R9 / R5
    wr(0, 8'h20); wr(5, 8'h77);
    rd(0, got); check("R8 R9 error status", got, 8'h30);
    wr(0, 8'hFF); rd(5, got); check("R8 no erase on bad confirm", got, ref_mem[5]);
    wr(0, 8'h70); rd(0, got); check("R8 status sticky", got, 8'h30);
    wr(0, 8'h50); rd(5, got); check("R5 clear goes array", got, ref_mem[5]);
    wr(0, 8'h70); rd(0, got); check("R5 status cleared", got, 8'h00);

    // R13: new command right after program data
    wr(0, 8'hFF);
    wr(0, 8'h40); wr(7, 8'h5A); ref_mem[7] = 8'h5A;
    wr(0, 8'h90); rd(1, got); check("R13 next byte is command", got, ID[15:8]);
    wr(0, 8'hFF); rd(7, got); check("R13 R6 programmed", got, 8'h5A);

    // R12: read and write together
    @(negedge clk); addr = 7; wdata = 8'h70; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    check("R12 read sees old mode", rdata, 8'h5A);
    rd(7, got); check("R12 new mode after", got, 8'h00);
    wr(0, 8'hFF); rd(7, got); check("R12 array again", got, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule